// File: doc/BRIEF.md
# Byte-Stream Command Parser

This block sits behind a serial slave that delivers one byte at a time. The slave marks each byte with a one-cycle begin strobe when the transfer starts and a one-cycle end strobe when the received byte is valid. The parser reads the first byte of a command as an opcode and the following bytes as header fields and data. It drives three storage ports with 16-bit words: a register file, a show-ahead FIFO, and a RAM. It also holds a single enable bit.

A read command needs the host to clock out dummy bytes. For each of those transfers the parser presents the reply byte on `tx_byte_o` before the transfer starts, and keeps it there until that transfer ends. The parser fetches the word once per 16-bit item and returns it as two bytes. A parameter chooses whether the low byte goes first.

Top module: `byte_cmd_parser`

## Requirements
- R1: `en_o` is 0 after reset. The single-byte opcode 0x01 sets it and the single-byte opcode 0x00 clears it.
- R2: Opcode 0x02 is followed by an address byte and a 16-bit data field. It writes the data to the register at that address with one `reg_we_o` pulse.
- R3: Opcode 0x03 is followed by an address byte and two dummy bytes. Those two transfers return the 16-bit content of the addressed register.
- R4: With the default `LSB_FIRST`=1, every 16-bit field (data, count, start address, reply) is carried low byte first and high byte second.
- R5: Opcode 0x04 is followed by a 16-bit word count and two bytes per word. Each word is pushed to the FIFO in arrival order, and a word that arrives while the FIFO is full is dropped.
- R6: Opcode 0x05 is followed by a 16-bit count and two dummy bytes per word. Each word pops the FIFO head and returns it. When the FIFO is empty the word returns 0 and nothing is popped.
- R7: Opcode 0x06 is followed by a 16-bit start address, a 16-bit count, and the data words. Word i is written to address start+i. A word whose address is at or above `RAM_DEPTH` (256) is ignored.
- R8: Opcode 0x07 has the same header as 0x06 and is followed by two dummy bytes per word. Word i returns RAM[start+i], or 0 when that address is at or above `RAM_DEPTH`.
- R9: A count of 0 ends a FIFO or RAM command right after its header. The next byte is taken as a new opcode.
- R10: An opcode above 0x07 returns the parser to idle without changing the enable bit or any storage. The next byte is taken as a new opcode.
- R11: During a read transfer, `tx_byte_o` carries that transfer's reply byte from 5 cycles after the previous end strobe until the transfer's own end strobe. On all other bytes it is 0.
- R12: Each data word causes at most one write strobe, and that strobe lasts one cycle. A full FIFO is never pushed and an empty FIFO is never popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beg_i | input | 1 | One-cycle strobe at the start of a byte transfer |
| end_i | input | 1 | One-cycle strobe when `rx_byte_i` holds the received byte |
| rx_byte_i | input | 8 | Byte received from the host |
| tx_byte_o | output | 8 | Reply byte for the current or next transfer |
| en_o | output | 1 | Enable control bit |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | REG_AW | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, combinational from `reg_addr_o` |
| fifo_we_o | output | 1 | FIFO push strobe |
| fifo_wdata_o | output | 16 | FIFO push data |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_re_o | output | 1 | FIFO pop strobe |
| fifo_rdata_i | input | 16 | FIFO head word (show-ahead) |
| fifo_empty_i | input | 1 | FIFO empty flag |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 16 | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, combinational from `ram_addr_o` |

## Verification
The hardest cases to reach from the ports are those where the storage limits cut into a burst that is already running:
- a FIFO write that overruns the free space;
- a FIFO read that drains past the last entry;
- a RAM burst whose start address lies just below 256, so only its first words land.

The bench reaches them with an eight-entry FIFO model and with start addresses drawn near the top of the RAM. The RAM model returns a nonzero marker for out-of-range addresses, so only a parser that forces the reply to 0 passes. Words stored at the bottom of the RAM are read back afterwards, which shows that the dropped words did not wrap around and overwrite them.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned HDR_MAX = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_OP, S_CTRL, S_HDR, S_SETUP,
    S_WR0, S_WR1, S_COMMIT,
    S_FETCH, S_ARM0, S_RD0, S_ARM1, S_RD1,
    S_STEP, S_BRANCH
  } state_e;

  typedef enum logic [1:0] {K_CTRL, K_REG, K_FIFO, K_RAM} kind_e;
  typedef enum logic [1:0] {RS_NONE, RS_FIRST, RS_SECOND} rsel_e;

  function automatic word_t join_bytes(byte_t first, byte_t second, bit lsb_first);
    return lsb_first ? {second, first} : {first, second};
  endfunction
endpackage

// File: rtl/cmdp_hdr.sv
module cmdp_hdr
  import cmdp_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        push_i,
  input  byte_t       byte_i,
  output logic [1:0]  idx_o,
  output byte_t       byte0_o,
  output word_t       f0_o,
  output word_t       f1_o
);
  byte_t      b_q [HDR_MAX];
  logic [1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (push_i) idx_q <= idx_q + 2'd1;
  end

  for (genvar g = 0; g < HDR_MAX; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           b_q[g] <= '0;
      else if (push_i && idx_q == 2'(g))     b_q[g] <= byte_i;
    end
  end

  assign idx_o   = idx_q;
  assign byte0_o = b_q[0];
  assign f0_o    = join_bytes(b_q[0], b_q[1], LSB_FIRST);
  assign f1_o    = join_bytes(b_q[2], b_q[3], LSB_FIRST);
endmodule

// File: rtl/cmdp_burst.sv
module cmdp_burst
  import cmdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  word_t             cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W:0]   addr_o,
  output logic              zero_o
);
  word_t           cnt_q;
  logic [ADDR_W:0] addr_q;

  // extra top bit keeps a run past the last address out of range
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      cnt_q  <= cnt_i;
      addr_q <= {1'b0, addr_i};
    end else if (step_i) begin
      cnt_q  <= cnt_q - 1'b1;
      addr_q <= addr_q[ADDR_W] ? addr_q : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cmdp_reply.sv
module cmdp_reply
  import cmdp_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  word_t word_i,
  input  rsel_e sel_i,
  output byte_t byte_o
);
  byte_t lo, hi;
  assign lo = word_i[BYTE_W-1:0];
  assign hi = word_i[WORD_W-1:BYTE_W];

  always_comb begin
    unique case (sel_i)
      RS_FIRST:  byte_o = LSB_FIRST ? lo : hi;
      RS_SECOND: byte_o = LSB_FIRST ? hi : lo;
      default:   byte_o = '0;
    endcase
  end
endmodule

// File: rtl/byte_cmd_parser.sv
module byte_cmd_parser
  import cmdp_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 256,
  parameter int unsigned REG_AW    = 8,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beg_i,
  input  logic              end_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_byte_o,
  output logic              en_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [15:0]       reg_wdata_o,
  input  logic [15:0]       reg_rdata_i,
  output logic              fifo_we_o,
  output logic [15:0]       fifo_wdata_o,
  input  logic              fifo_full_i,
  output logic              fifo_re_o,
  input  logic [15:0]       fifo_rdata_i,
  input  logic              fifo_empty_i,
  output logic              ram_we_o,
  output logic [15:0]       ram_addr_o,
  output logic [15:0]       ram_wdata_o,
  input  logic [15:0]       ram_rdata_i
);
  localparam int unsigned     ADDR_W  = WORD_W;
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W + 1)'(RAM_DEPTH);

  state_e state_q, state_d;
  byte_t  op_q, lo_q;
  word_t  word_q, wdata_q;
  logic   en_q;

  logic            op_ok, is_rd;
  kind_e           kind;
  logic [1:0]      hdr_last, hdr_idx;
  byte_t           hdr_b0;
  word_t           hdr_f0, hdr_f1, ld_cnt;
  logic [ADDR_W-1:0] ld_addr;
  logic [ADDR_W:0] run_addr;
  logic            cnt_zero, in_range;
  rsel_e           rsel;

  assign op_ok = (op_q[7:3] == '0);
  assign kind  = kind_e'(op_q[2:1]);
  assign is_rd = op_q[0];

  always_comb begin
    unique case (kind)
      K_REG:   hdr_last = 2'd0;
      K_FIFO:  hdr_last = 2'd1;
      default: hdr_last = 2'd3;
    endcase
  end

  cmdp_hdr #(.LSB_FIRST(LSB_FIRST)) u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == S_OP),
    .push_i  (state_q == S_HDR && end_i),
    .byte_i  (rx_byte_i),
    .idx_o   (hdr_idx),
    .byte0_o (hdr_b0),
    .f0_o    (hdr_f0),
    .f1_o    (hdr_f1)
  );

  always_comb begin
    unique case (kind)
      K_FIFO:  begin ld_cnt = hdr_f0; ld_addr = '0; end
      K_RAM:   begin ld_cnt = hdr_f1; ld_addr = hdr_f0; end
      default: begin ld_cnt = word_t'(1); ld_addr = ADDR_W'(hdr_b0); end
    endcase
  end

  cmdp_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_SETUP),
    .cnt_i  (ld_cnt),
    .addr_i (ld_addr),
    .step_i (state_q == S_STEP),
    .addr_o (run_addr),
    .zero_o (cnt_zero)
  );

  assign in_range = (run_addr < DEPTH_C);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (beg_i) state_d = S_OP;
      S_OP:     if (end_i) begin
                  if (rx_byte_i[7:1] == '0)      state_d = S_CTRL;
                  else if (rx_byte_i[7:3] == '0) state_d = S_HDR;
                  else                           state_d = S_IDLE;
                end
      S_CTRL:   state_d = S_IDLE;
      S_HDR:    if (end_i && hdr_idx == hdr_last) state_d = S_SETUP;
      S_SETUP:  if (ld_cnt == '0) state_d = S_IDLE;
                else              state_d = is_rd ? S_FETCH : S_WR0;
      S_WR0:    if (end_i) state_d = S_WR1;
      S_WR1:    if (end_i) state_d = S_COMMIT;
      S_COMMIT: state_d = S_STEP;
      S_FETCH:  state_d = S_ARM0;
      S_ARM0:   if (beg_i) state_d = S_RD0;
      S_RD0:    if (end_i) state_d = S_ARM1;
      S_ARM1:   if (beg_i) state_d = S_RD1;
      S_RD1:    if (end_i) state_d = S_STEP;
      S_STEP:   state_d = S_BRANCH;
      S_BRANCH: if (cnt_zero) state_d = S_IDLE;
                else          state_d = is_rd ? S_FETCH : S_WR0;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      lo_q    <= '0;
      wdata_q <= '0;
      word_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_OP && end_i)  op_q <= rx_byte_i;
      if (state_q == S_CTRL && op_ok) en_q <= op_q[0];
      if (state_q == S_WR0 && end_i) lo_q <= rx_byte_i;
      if (state_q == S_WR1 && end_i) wdata_q <= join_bytes(lo_q, rx_byte_i, LSB_FIRST);
      if (state_q == S_FETCH) begin
        unique case (kind)
          K_FIFO:  word_q <= fifo_empty_i ? '0 : fifo_rdata_i;
          K_RAM:   word_q <= in_range ? ram_rdata_i : '0;
          default: word_q <= reg_rdata_i;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      S_ARM0, S_RD0: rsel = RS_FIRST;
      S_ARM1, S_RD1: rsel = RS_SECOND;
      default:       rsel = RS_NONE;
    endcase
  end

  cmdp_reply #(.LSB_FIRST(LSB_FIRST)) u_reply (
    .word_i (word_q),
    .sel_i  (rsel),
    .byte_o (tx_byte_o)
  );

  assign en_o         = en_q;
  assign reg_addr_o   = run_addr[REG_AW-1:0];
  assign ram_addr_o   = run_addr[ADDR_W-1:0];
  assign reg_wdata_o  = wdata_q;
  assign fifo_wdata_o = wdata_q;
  assign ram_wdata_o  = wdata_q;
  assign reg_we_o     = (state_q == S_COMMIT) && (kind == K_REG);
  assign fifo_we_o    = (state_q == S_COMMIT) && (kind == K_FIFO) && !fifo_full_i;
  assign ram_we_o     = (state_q == S_COMMIT) && (kind == K_RAM) && in_range;
  assign fifo_re_o    = (state_q == S_FETCH) && (kind == K_FIFO) && !fifo_empty_i;
endmodule

// File: rtl/byte_cmd_parser_chk.sv
module byte_cmd_parser_chk
  import cmdp_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        beg_i,
  input logic        end_i,
  input state_e      state_q,
  input logic [7:0]  tx_byte_o,
  input logic        en_o,
  input logic        reg_we_o,
  input logic        fifo_we_o,
  input logic        fifo_full_i,
  input logic        fifo_re_o,
  input logic        fifo_empty_i,
  input logic        ram_we_o,
  input logic [15:0] ram_addr_o
);
  AST_EN_FROM_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_o) |-> $past(state_q) == S_CTRL); // R1
  AST_FIFO_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> !fifo_full_i); // R5
  AST_FIFO_POP_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_re_o |-> !fifo_empty_i); // R6
  AST_RAM_WE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> 32'(ram_addr_o) < RAM_DEPTH); // R7
  AST_TX_HOLD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD0 && !end_i) |=> $stable(tx_byte_o)); // R11
  AST_TX_HOLD_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD1 && !end_i) |=> $stable(tx_byte_o)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, fifo_we_o, ram_we_o, fifo_re_o})); // R12
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || fifo_we_o || ram_we_o) |=> !(reg_we_o || fifo_we_o || ram_we_o)); // R12
endmodule

bind byte_cmd_parser byte_cmd_parser_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beg_i        (beg_i),
  .end_i        (end_i),
  .state_q      (state_q),
  .tx_byte_o    (tx_byte_o),
  .en_o         (en_o),
  .reg_we_o     (reg_we_o),
  .fifo_we_o    (fifo_we_o),
  .fifo_full_i  (fifo_full_i),
  .fifo_re_o    (fifo_re_o),
  .fifo_empty_i (fifo_empty_i),
  .ram_we_o     (ram_we_o),
  .ram_addr_o   (ram_addr_o)
);

// File: tb/tb_byte_cmd_parser.sv
module tb_byte_cmd_parser;
  localparam bit LSB    = 1'b1;
  localparam int FDEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, beg_s = 1'b0, end_s = 1'b0;
  logic [7:0]  rx_s = '0;
  logic [7:0]  tx_byte;
  logic        en, reg_we, fifo_we, fifo_re, ram_we, fifo_full, fifo_empty;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, fifo_wdata, fifo_rdata, ram_addr, ram_wdata, ram_rdata;

  int n_chk = 0, n_err = 0, n_regwe = 0, hold_bad = 0, tx_bad = 0;
  bit done = 1'b0;

  logic [15:0] mdl_reg [256];
  logic [15:0] mdl_ram [256];
  logic [15:0] mdl_fifo [$];
  logic [15:0] fifo_head = 16'hBEEF;
  int          fifo_n = 0;

  logic [15:0] exp_reg [256];
  logic [15:0] exp_ram [256];
  logic [15:0] exp_fifo [$];
  logic [15:0] wbuf [16];

  always #2 clk = ~clk;

  byte_cmd_parser dut (
    .clk_i (clk), .rst_ni (rst_n), .beg_i (beg_s), .end_i (end_s),
    .rx_byte_i (rx_s), .tx_byte_o (tx_byte), .en_o (en),
    .reg_we_o (reg_we), .reg_addr_o (reg_addr), .reg_wdata_o (reg_wdata), .reg_rdata_i (reg_rdata),
    .fifo_we_o (fifo_we), .fifo_wdata_o (fifo_wdata), .fifo_full_i (fifo_full),
    .fifo_re_o (fifo_re), .fifo_rdata_i (fifo_rdata), .fifo_empty_i (fifo_empty),
    .ram_we_o (ram_we), .ram_addr_o (ram_addr), .ram_wdata_o (ram_wdata), .ram_rdata_i (ram_rdata)
  );

  assign reg_rdata  = mdl_reg[reg_addr];
  assign ram_rdata  = (ram_addr < 16'd256) ? mdl_ram[ram_addr[7:0]] : 16'hDEAD;
  assign fifo_rdata = fifo_head;
  assign fifo_full  = (fifo_n == FDEPTH);
  assign fifo_empty = (fifo_n == 0);

  always @(posedge clk) begin
    if (reg_we) begin mdl_reg[reg_addr] <= reg_wdata; n_regwe++; end
    if (ram_we) mdl_ram[ram_addr[7:0]] <= ram_wdata;
    if (fifo_we && mdl_fifo.size() < FDEPTH) mdl_fifo.push_back(fifo_wdata);
    if (fifo_re && mdl_fifo.size() > 0) void'(mdl_fifo.pop_front());
    fifo_n    <= mdl_fifo.size();
    fifo_head <= (mdl_fifo.size() > 0) ? mdl_fifo[0] : 16'hBEEF;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso);
    @(negedge clk); beg_s = 1'b1; miso = tx_byte;
    @(negedge clk); beg_s = 1'b0;
    repeat (6) @(negedge clk);
    if (tx_byte !== miso) hold_bad++;
    rx_s = mosi; end_s = 1'b1;
    @(negedge clk); end_s = 1'b0; rx_s = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] m;
    xfer(b, m);
    if (m !== 8'h00) tx_bad++;
  endtask

  task automatic put16(input logic [15:0] w);
    if (LSB) begin put(w[7:0]); put(w[15:8]); end
    else     begin put(w[15:8]); put(w[7:0]); end
  endtask

  task automatic get16(output logic [15:0] w);
    logic [7:0] a, b;
    xfer(8'h00, a); xfer(8'h00, b);
    w = LSB ? {b, a} : {a, b};
  endtask

  task automatic cmd_wreg(input logic [7:0] a, input logic [15:0] d);
    put(8'h02); put(a); put16(d); exp_reg[a] = d;
  endtask

  task automatic cmd_rreg(input logic [7:0] a, input string req);
    logic [15:0] w;
    put(8'h03); put(a); get16(w);
    chk(req, w, exp_reg[a]);
  endtask

  task automatic cmd_wfifo(input int n);
    put(8'h04); put16(16'(n));
    for (int i = 0; i < n; i++) begin
      put16(wbuf[i]);
      if (exp_fifo.size() < FDEPTH) exp_fifo.push_back(wbuf[i]);
    end
  endtask

  task automatic cmd_rfifo(input int n, input string req);
    logic [15:0] w, e;
    put(8'h05); put16(16'(n));
    for (int i = 0; i < n; i++) begin
      get16(w);
      e = (exp_fifo.size() > 0) ? exp_fifo.pop_front() : 16'h0000;
      chk(req, w, e);
    end
  endtask

  task automatic cmd_wram(input int a, input int n);
    put(8'h06); put16(16'(a)); put16(16'(n));
    for (int i = 0; i < n; i++) begin
      put16(wbuf[i]);
      if (a + i < 256) exp_ram[a + i] = wbuf[i];
    end
  endtask

  task automatic cmd_rram(input int a, input int n, input string req);
    logic [15:0] w;
    put(8'h07); put16(16'(a)); put16(16'(n));
    for (int i = 0; i < n; i++) begin
      get16(w);
      chk(req, w, (a + i < 256) ? exp_ram[a + i] : 16'h0000);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  m0, m1;
    logic [15:0] w;
    int          k;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) begin
      mdl_reg[i] = '0; mdl_ram[i] = '0; exp_reg[i] = '0; exp_ram[i] = '0;
    end
    repeat (4) @(negedge clk);
    chk("R1 reset en", en, 0);
    chk("R11 reset tx", tx_byte, 0);
    chk("R12 reset strobes", {reg_we, fifo_we, ram_we, fifo_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    put(8'h01); chk("R1 set", en, 1);
    put(8'h00); chk("R1 clear", en, 0);
    put(8'h01); chk("R1 set again", en, 1);

    // R4 low byte first on the wire
    k = n_regwe;
    put(8'h02); put(8'h10); put(8'h34); put(8'h12);
    exp_reg[8'h10] = 16'h1234;
    chk("R12 one reg strobe", n_regwe - k, 1);
    chk("R2 reg stored", mdl_reg[8'h10], 16'h1234);
    put(8'h03); put(8'h10); xfer(8'h00, m0); xfer(8'h00, m1);
    chk("R4 first reply byte", m0, 8'h34);
    chk("R4 second reply byte", m1, 8'h12);
    cmd_wreg(8'hFF, 16'hA55A);
    cmd_rreg(8'hFF, "R3 reg read");
    cmd_rreg(8'h10, "R3 reg read other");

    for (int i = 0; i < 16; i++) wbuf[i] = 16'(32'h1000 + i * 32'h0111);
    cmd_wfifo(3);
    cmd_rfifo(3, "R5 fifo order");
    cmd_wfifo(10);
    chk("R5 fifo drop when full", fifo_n, FDEPTH);
    cmd_rfifo(10, "R6 fifo drain then zero");
    chk("R6 no pop on empty", fifo_n, 0);
    cmd_wfifo(1);
    cmd_rfifo(1, "R6 fifo after underflow");

    wbuf[0] = 16'hAAAA;
    cmd_wram(0, 1);
    for (int i = 0; i < 4; i++) wbuf[i] = 16'(32'h7700 + i);
    cmd_wram(5, 4);
    cmd_rram(5, 4, "R8 ram burst read");
    for (int i = 0; i < 4; i++) wbuf[i] = 16'(32'h5500 + i);
    cmd_wram(254, 4);
    cmd_rram(254, 4, "R8 ram read past depth");
    cmd_rram(0, 1, "R7 no wrap on ignored write");

    // R9 zero counts
    put(8'h00);
    put(8'h04); put16(16'h0000);
    put(8'h01);
    chk("R9 zero fifo count", en, 1);
    put(8'h07); put16(16'h0003); put16(16'h0000);
    put(8'h00);
    chk("R9 zero ram count", en, 0);
    chk("R9 fifo untouched", fifo_n, 0);

    // R10 unknown opcodes
    put(8'h01);
    put(8'h2A);
    chk("R10 en kept", en, 1);
    put(8'h00);
    chk("R10 next byte is opcode", en, 0);
    put(8'hFF); put(8'h01);
    chk("R10 after 0xFF", en, 1);
    cmd_rreg(8'hFF, "R10 regs kept");

    for (int it = 0; it < 40; it++) begin
      int op, n, a;
      op = int'($urandom_range(0, 5));
      n  = int'($urandom_range(0, 6));
      for (int i = 0; i < 16; i++) wbuf[i] = 16'($urandom);
      a  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(250, 258)) : int'($urandom_range(0, 255));
      case (op)
        0: cmd_wreg(8'(a), wbuf[0]);
        1: cmd_rreg(8'($urandom_range(0, 255)), "R3 random reg read");
        2: cmd_wfifo(n);
        3: cmd_rfifo(n, "R6 random fifo read");
        4: cmd_wram(a, n);
        default: cmd_rram(a, n, "R8 random ram read");
      endcase
    end
    cmd_rram(248, 8, "R7 random ram final");

    chk("R11 reply held through transfer", hold_bad, 0);
    chk("R11 zero on non-read bytes", tx_bad, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule